// File: doc/BRIEF.md
# Interrupt Priority Presenter

This block keeps the interrupt priority state for one processor context. Notifications arrive on a strobe with an 8-bit priority code. Each legal one marks its level in an 8-entry pending buffer. The most favoured pending level is derived from that buffer and compared against a current-priority register that software writes. When a pending level beats the current priority, a level-sensitive interrupt line rises and an exception-pending flag is set.

Lower numbers are more favoured, and the legal levels are 0 to 7. Level 0 occupies the top bit of the buffer. An acknowledge strobe retires the level that is currently most favoured and clears the exception flag. Priority state is re-evaluated after every change, so the line drops as soon as the condition lapses.

Top module: `irq_prio_presenter`

## Requirements
- R1: A notification (notif_valid_i high) with priority p in 0..7 sets bit (7 - p) of pend_buf_o at the next clock edge. Bits that are already set stay set.
- R2: A notification whose priority is in 8..0xFE leaves pend_buf_o unchanged.
- R3: A notification with priority 0xFF is dropped and leaves pend_buf_o and pend_prio_o unchanged.
- R4: pend_prio_o is registered on the same edge as pend_buf_o. It holds the count of leading zeros of the new buffer, or 0xFF when the buffer is empty.
- R5: A write (cur_prio_we_i) with a value in 0..7 or equal to 0xFF loads cur_prio_o at the next edge. Any value in 8..0xFE is ignored and leaves cur_prio_o unchanged.
- R6: irq_o is high in a cycle exactly when the previous cycle had pend_prio_o strictly less than cur_prio_o. Equal values do not signal.
- R7: exc_pend_o is set one edge after the condition of R6 holds. It stays set until an acknowledge.
- R8: ack_i clears the pending bit of the current pend_prio_o and clears exc_pend_o at the next edge. If a notification arrives in the same cycle, it still sets its own bit.
- R9: After reset, pend_buf_o = 0, pend_prio_o = 0xFF, cur_prio_o = 0, and irq_o and exc_pend_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| notif_valid_i | input | 1 | Notification strobe |
| notif_prio_i | input | 8 | Notification priority code |
| cur_prio_we_i | input | 1 | Current-priority write strobe |
| cur_prio_wdata_i | input | 8 | Current-priority write value |
| ack_i | input | 1 | Acknowledge of the most favoured pending level |
| pend_buf_o | output | 8 | Pending buffer, bit 7 = priority 0 |
| pend_prio_o | output | 8 | Most favoured pending priority, 0xFF if none |
| cur_prio_o | output | 8 | Current processor priority |
| exc_pend_o | output | 1 | Exception-pending flag |
| irq_o | output | 1 | Level interrupt to the processor |

## Verification
The assertions assume that every input is a clean synchronous level that changes only between clock edges. They also assume that an acknowledge always targets whatever pend_prio_o shows at that moment, so no check tracks an acknowledge against a stale priority. The stimulus changes inputs only on the falling edge and holds each strobe for exactly one rising edge. Strobes are otherwise deasserted, so each property sees one defined transaction per edge.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned PRIO_W    = 3;
  localparam int unsigned NUM_LVL   = 1 << PRIO_W;
  localparam int unsigned CODE_W    = 8;
  localparam logic [CODE_W-1:0] MAX_PRIO  = CODE_W'(NUM_LVL - 1);
  localparam logic [CODE_W-1:0] NONE_CODE = '1;

  // leading-zero count of the pending buffer, NONE_CODE when empty
  function automatic logic [CODE_W-1:0] lead_zero(input logic [NUM_LVL-1:0] b);
    logic [CODE_W-1:0] r;
    r = NONE_CODE;
    for (int i = 0; i < NUM_LVL; i++)
      if (b[i]) r = CODE_W'(NUM_LVL - 1 - i);
    return r;
  endfunction
endpackage

// File: rtl/prio_pend_buf.sv
module prio_pend_buf
  import irq_prio_pkg::*;
#(
  parameter int unsigned LVL = NUM_LVL,
  parameter int unsigned CW  = CODE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          notif_valid_i,
  input  logic [CW-1:0] notif_prio_i,
  input  logic          ack_i,
  output logic [LVL-1:0] buf_o,
  output logic [CW-1:0] prio_o
);
  logic [LVL-1:0] set_mask, clr_mask, buf_d, buf_q;
  logic [CW-1:0]  prio_q;

  // level g lands on bit LVL-1-g
  for (genvar g = 0; g < LVL; g++) begin : g_lvl
    assign set_mask[LVL-1-g] = notif_valid_i && (notif_prio_i == CW'(g));
    assign clr_mask[LVL-1-g] = ack_i && (prio_q == CW'(g));
  end

  assign buf_d = (buf_q & ~clr_mask) | set_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      prio_q <= NONE_CODE;
    end else begin
      buf_q  <= buf_d;
      prio_q <= lead_zero(buf_d);
    end
  end

  assign buf_o  = buf_q;
  assign prio_o = prio_q;
endmodule

// File: rtl/prio_cur_reg.sv
module prio_cur_reg
  import irq_prio_pkg::*;
#(
  parameter int unsigned CW = CODE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] cur_o
);
  logic          legal;
  logic [CW-1:0] cur_q;

  assign legal = (wdata_i <= MAX_PRIO) || (wdata_i == NONE_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cur_q <= '0;
    else if (we_i && legal) cur_q <= wdata_i;
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/prio_irq_eval.sv
module prio_irq_eval
  import irq_prio_pkg::*;
#(
  parameter int unsigned CW = CODE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] pend_prio_i,
  input  logic [CW-1:0] cur_prio_i,
  input  logic          ack_i,
  output logic          exc_o,
  output logic          irq_o
);
  logic fire, exc_q, irq_q;

  assign fire = pend_prio_i < cur_prio_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= fire;
      exc_q <= ack_i ? 1'b0 : (exc_q | fire);
    end
  end

  assign exc_o = exc_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/irq_prio_presenter.sv
module irq_prio_presenter
  import irq_prio_pkg::*;
#(
  parameter int unsigned LVL = NUM_LVL,
  parameter int unsigned CW  = CODE_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           notif_valid_i,
  input  logic [CW-1:0]  notif_prio_i,
  input  logic           cur_prio_we_i,
  input  logic [CW-1:0]  cur_prio_wdata_i,
  input  logic           ack_i,
  output logic [LVL-1:0] pend_buf_o,
  output logic [CW-1:0]  pend_prio_o,
  output logic [CW-1:0]  cur_prio_o,
  output logic           exc_pend_o,
  output logic           irq_o
);
  prio_pend_buf #(.LVL(LVL), .CW(CW)) u_pend (
    .clk_i, .rst_ni, .notif_valid_i, .notif_prio_i, .ack_i,
    .buf_o(pend_buf_o), .prio_o(pend_prio_o)
  );

  prio_cur_reg #(.CW(CW)) u_cur (
    .clk_i, .rst_ni, .we_i(cur_prio_we_i), .wdata_i(cur_prio_wdata_i),
    .cur_o(cur_prio_o)
  );

  prio_irq_eval #(.CW(CW)) u_eval (
    .clk_i, .rst_ni, .pend_prio_i(pend_prio_o), .cur_prio_i(cur_prio_o),
    .ack_i, .exc_o(exc_pend_o), .irq_o
  );
endmodule

// File: rtl/irq_prio_presenter_chk.sv
module irq_prio_presenter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       notif_valid_i,
  input logic [7:0] notif_prio_i,
  input logic       cur_prio_we_i,
  input logic [7:0] cur_prio_wdata_i,
  input logic       ack_i,
  input logic [7:0] pend_buf_o,
  input logic [7:0] pend_prio_o,
  input logic [7:0] cur_prio_o,
  input logic       exc_pend_o,
  input logic       irq_o
);
  a_r1_set_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (notif_valid_i && notif_prio_i < 8'd8) |=> pend_buf_o[~$past(notif_prio_i[2:0])]);

  a_r2_r3_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (notif_valid_i && notif_prio_i > 8'd7 && !ack_i) |=> $stable(pend_buf_o));

  a_r4_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_buf_o == 8'h00) |-> (pend_prio_o == 8'hFF));

  a_r4_top_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_buf_o != 8'h00) |-> (pend_prio_o < 8'd8 && pend_buf_o[~pend_prio_o[2:0]]));

  a_r5_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_prio_we_i && cur_prio_wdata_i > 8'd7 && cur_prio_wdata_i != 8'hFF) |=> $stable(cur_prio_o));

  a_r6_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(pend_prio_o < cur_prio_o)));

  a_r7_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exc_pend_o) |-> $past(pend_prio_o < cur_prio_o));

  a_r8_ack_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !exc_pend_o);
endmodule

bind irq_prio_presenter irq_prio_presenter_chk u_chk (
  .clk_i, .rst_ni, .notif_valid_i, .notif_prio_i, .cur_prio_we_i,
  .cur_prio_wdata_i, .ack_i, .pend_buf_o, .pend_prio_o, .cur_prio_o,
  .exc_pend_o, .irq_o
);

// File: tb/irq_prio_presenter_bench.sv
`timescale 1ns/1ps
module irq_prio_presenter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nv = 1'b0;
  logic [7:0] np = '0;
  logic       we = 1'b0;
  logic [7:0] wd = '0;
  logic       ack = 1'b0;
  logic [7:0] pbuf, pprio, cprio;
  logic       exc, irq;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_prio_presenter u_irq_prio_presenter (
    .clk_i(clk), .rst_ni(rst_n), .notif_valid_i(nv), .notif_prio_i(np),
    .cur_prio_we_i(we), .cur_prio_wdata_i(wd), .ack_i(ack),
    .pend_buf_o(pbuf), .pend_prio_o(pprio), .cur_prio_o(cprio),
    .exc_pend_o(exc), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one rising edge, then back to the falling edge with strobes dropped
  task automatic tick();
    @(posedge clk); @(negedge clk);
    nv = 0; we = 0; ack = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; nv = 0; we = 0; ack = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic notify(input logic [7:0] p); nv = 1; np = p; tick(); endtask
  task automatic wr_cur(input logic [7:0] v); we = 1; wd = v; tick(); endtask

  task automatic t_reset();
    do_reset();
    chk("R9 buf", pbuf, 8'h00);
    chk("R9 pprio", pprio, 8'hFF);
    chk("R9 cur", cprio, 8'h00);
    chk("R9 irq", {7'b0, irq}, 8'h00);
    chk("R9 exc", {7'b0, exc}, 8'h00);
  endtask

  task automatic t_raise_and_ack();
    do_reset();
    notify(8'd3);
    chk("R1 buf p3", pbuf, 8'h10);
    chk("R4 pprio p3", pprio, 8'd3);
    chk("R6 no irq cur0", {7'b0, irq}, 8'h00);
    wr_cur(8'd5);
    chk("R5 cur load", cprio, 8'd5);
    tick();
    chk("R6 irq up", {7'b0, irq}, 8'h01);
    chk("R7 exc set", {7'b0, exc}, 8'h01);
    ack = 1; tick();
    chk("R8 buf cleared", pbuf, 8'h00);
    chk("R8 exc cleared", {7'b0, exc}, 8'h00);
    chk("R4 empty pprio", pprio, 8'hFF);
    tick();
    chk("R6 irq down", {7'b0, irq}, 8'h00);
    chk("R7 exc stays low", {7'b0, exc}, 8'h00);
  endtask

  task automatic t_multi();
    do_reset();
    notify(8'd6);
    notify(8'd2);
    chk("R1 two bits", pbuf, 8'h22);
    chk("R4 lzc two", pprio, 8'd2);
    notify(8'd0);
    chk("R1 prio0 msb", pbuf, 8'hA2);
    chk("R4 lzc zero", pprio, 8'd0);
    ack = 1; tick();
    chk("R8 ack top", pbuf, 8'h22);
    ack = 1; nv = 1; np = 8'd2; tick();
    chk("R8 ack vs notify", pbuf, 8'h22);
    chk("R4 after race", pprio, 8'd2);
  endtask

  task automatic t_drop();
    do_reset();
    notify(8'd7);
    chk("R1 p7 lsb", pbuf, 8'h01);
    notify(8'd9);
    chk("R2 p9 ignored", pbuf, 8'h01);
    notify(8'hFE);
    chk("R2 pFE ignored", pbuf, 8'h01);
    notify(8'hFF);
    chk("R3 masked buf", pbuf, 8'h01);
    chk("R3 masked pprio", pprio, 8'd7);
  endtask

  task automatic t_cur_prio();
    do_reset();
    notify(8'd4);
    wr_cur(8'd4);
    tick();
    chk("R6 equal no irq", {7'b0, irq}, 8'h00);
    wr_cur(8'd9);
    chk("R5 9 ignored", cprio, 8'd4);
    wr_cur(8'hFF);
    chk("R5 FF accepted", cprio, 8'hFF);
    tick();
    chk("R6 irq under FF", {7'b0, irq}, 8'h01);
    wr_cur(8'd1);
    tick();
    chk("R6 level drops", {7'b0, irq}, 8'h00);
    chk("R7 exc sticky", {7'b0, exc}, 8'h01);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_raise_and_ack();
        t_multi();
        t_drop();
        t_cur_prio();
        done = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_run++; n_fail++;
          $display("FAIL watchdog actual=timeout expected=finish");
        end
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule